// File: doc/BRIEF.md
# Windowed Heartbeat Watchdog

This block supervises a processor heartbeat on `wdi_i` and drives an active-low reset request on `wdo_no`. The processor services the watchdog by pulling `wdi_i` low. A service that comes too soon counts as a failure, and so does a service that comes too late. Every interval is derived from a single base period `T`, given in clock cycles by the parameter `T_RST_CYC`:
- the reset pulse lasts `T`;
- the early-service window lasts `T/4`;
- the upper limit after an accepted service is `8*T`;
- the upper limit after the end of a reset pulse is `64*T`.

Each failure holds `wdo_no` low for one base period. The output is then released and supervision starts again. An undervoltage input clears the block at once and restarts the reset pulse. A reset input does the same.

The heartbeat is first passed through a two-flop synchronizer. It then goes through a level filter, so a level must persist for `FILT_CYC` clock cycles before it is believed.

Top module: `win_watchdog`

## Requirements
- R1: Only a filtered high-to-low transition of `wdi_i` is a service. A low-to-high transition has no effect on `wdo_no`, even when it lands inside the early window.
- R2: While `rst_ni` is low, `wdo_no` is 0. After `rst_ni` is released between edges R and R+1, `wdo_no` stays 0 through edge R+T-1 and becomes 1 at edge R+T.
- R3: A reset pulse that begins at edge P keeps `wdo_no` at 0 for exactly `T` cycles and releases it at edge P+T.
- R4: A service is early when it is acted on at edge E+k with k <= T/4, where E is the edge of the last release or accepted service. An early service drives `wdo_no` to 0 at that edge and starts a reset pulse.
- R5: A service acted on at edge E+k with k >= T/4+1 is accepted. `wdo_no` stays 1 and the timing restarts from that edge.
- R6: When an accepted service at edge K is followed by no service, a reset pulse starts at edge K+8*T. A service acted on at exactly edge K+8*T is still accepted.
- R7: When a reset pulse released at edge E is followed by no service, a new pulse starts at edge E+64*T.
- R8: `uvlo_i` high forces `wdo_no` to 0 asynchronously, without waiting for a clock. After `uvlo_i` falls between edges Y and Y+1, `wdo_no` becomes 1 at edge Y+T.
- R9: `wdi_i` must be held for at least `FILT_CYC` cycles to change the filtered level. A low held for exactly `FILT_CYC` cycles is a service. A low held for fewer cycles is ignored. A fall driven between edges X and X+1 is acted on at edge X+3+`FILT_CYC`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wdi_i | input | 1 | Asynchronous heartbeat from the processor |
| uvlo_i | input | 1 | Supply undervoltage; high clears the watchdog |
| wdo_no | output | 1 | Registered active-low reset request |

## Verification
A heartbeat fall is acted on `3+FILT_CYC` edges after it is driven: two synchronizer edges, `FILT_CYC` filter edges and one edge in the timer. Every change of `wdo_no` occurs on the edge computed from the R2–R8 formulas. The bench therefore times each stimulus so that it is acted on at a chosen edge. It samples `wdo_no` at the falling clock edge of that edge and of the edge before it, so an error of one cycle in either direction is caught. For undervoltage, the bench also samples one time unit after assertion, with no clock edge in between.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  typedef enum logic {
    WD_HOLD  = 1'b0,
    WD_WATCH = 1'b1
  } wd_state_e;
endpackage

// File: rtl/wwd_in_filter.sv
module wwd_in_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdi_i,
  output logic fall_o
);
  localparam int FW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);

  logic          sync1_q, sync2_q, lvl_q;
  logic [FW-1:0] run_q;
  logic          commit;

  assign commit = (sync2_q != lvl_q) && (run_q == FW'(FILT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= wdi_i;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b1;
      run_q  <= '0;
      fall_o <= 1'b0;
    end else begin
      fall_o <= commit && !sync2_q;
      if (sync2_q == lvl_q) begin
        run_q <= '0;
      end else if (commit) begin
        lvl_q <= sync2_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R1: a service pulse only follows a high-to-low move of the filtered level
  a_r1_fall_from_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!lvl_q && $past(lvl_q)));
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/wwd_core.sv
module wwd_core
  import wwd_pkg::*;
#(
  parameter int T_RST_CYC = 64
) (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic fall_i,
  output logic wdo_no_o
);
  localparam int LOW_CYC = T_RST_CYC / 4;
  localparam int LIM_S   = 8 * T_RST_CYC;
  localparam int LIM_L   = 64 * T_RST_CYC;
  localparam int CW      = $clog2(LIM_L);

  wd_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          long_q, long_d, early;

  assign lim   = long_q ? CW'(LIM_L - 1) : CW'(LIM_S - 1);
  assign early = cnt_q < CW'(LOW_CYC);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    long_d  = long_q;
    unique case (state_q)
      WD_HOLD: begin
        if (cnt_q == CW'(T_RST_CYC - 1)) begin
          state_d = WD_WATCH;
          cnt_d   = '0;
          long_d  = 1'b1;
        end
      end
      WD_WATCH: begin
        if (fall_i) begin
          cnt_d = '0;
          if (early) begin
            state_d = WD_HOLD;
          end else begin
            long_d = 1'b0;
          end
        end else if (cnt_q == lim) begin
          state_d = WD_HOLD;
          cnt_d   = '0;
        end
      end
      default: state_d = WD_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      state_q  <= WD_HOLD;
      cnt_q    <= '0;
      long_q   <= 1'b1;
      wdo_no_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      long_q   <= long_d;
      wdo_no_o <= (state_d == WD_WATCH);
    end
  end

  a_r3_release_after_pulse: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (state_q == WD_HOLD && cnt_q == CW'(T_RST_CYC - 1)) |=> (wdo_no_o && cnt_q == '0));
  a_r3_hold_keeps_low: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (state_q == WD_HOLD && cnt_q != CW'(T_RST_CYC - 1)) |=> !wdo_no_o);
  a_r4_early_fails: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (state_q == WD_WATCH && fall_i && cnt_q < CW'(LOW_CYC)) |=> !wdo_no_o);
  a_r5_late_accepts: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (state_q == WD_WATCH && fall_i && cnt_q >= CW'(LOW_CYC)) |=> (wdo_no_o && cnt_q == '0 && !long_q));
  a_r6_timeout: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (state_q == WD_WATCH && !fall_i && cnt_q == lim) |=> !wdo_no_o);
  a_r7_long_after_release: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (state_q == WD_HOLD && cnt_q == CW'(T_RST_CYC - 1)) |=> long_q);
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int T_RST_CYC = 64,
  parameter int FILT_CYC  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdi_i,
  input  logic uvlo_i,
  output logic wdo_no
);
  logic fall;
  logic clr_n;

  // undervoltage acts as an asynchronous clear of the timer only
  assign clr_n = rst_ni & ~uvlo_i;

  wwd_in_filter #(
    .FILT_CYC(FILT_CYC)
  ) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wdi_i (wdi_i),
    .fall_o(fall)
  );

  wwd_core #(
    .T_RST_CYC(T_RST_CYC)
  ) u_core (
    .clk_i   (clk_i),
    .clr_ni  (clr_n),
    .fall_i  (fall),
    .wdo_no_o(wdo_no)
  );

  a_r8_uvlo_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |-> !wdo_no);
  a_r2_reset_low: assert property (@(posedge clk_i) disable iff (uvlo_i)
    !rst_ni |-> !wdo_no);
endmodule

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T   = 32;
  localparam int N   = 3;
  localparam int Q   = T / 4;
  localparam int LS  = 8 * T;
  localparam int LL  = 64 * T;
  localparam int LAT = 3 + N;

  logic clk = 1'b0, rst_n = 1'b0, wdi = 1'b1, uvlo = 1'b0;
  logic wdo_n;
  int cyc = 0, total = 0, bad = 0;
  int er, k1, k2, t1, e, a, y;

  win_watchdog #(.T_RST_CYC(T), .FILT_CYC(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wdi_i(wdi), .uvlo_i(uvlo), .wdo_no(wdo_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic wait_cyc(input int c);
    if (cyc > c) begin
      total++; bad++;
      $display("FAIL bench schedule cyc=%0d expected <= %0d", cyc, c);
    end
    while (cyc < c) begin @(posedge clk); #1; end
  endtask

  task automatic check_at(input int c, input logic exp, input string tag);
    wait_cyc(c);
    @(negedge clk);
    total++;
    if (wdo_n !== exp) begin
      bad++;
      $display("FAIL %s cyc=%0d wdo_n=%b expected %b", tag, c, wdo_n, exp);
    end
  endtask

  task automatic pulse_low(input int x, input int len);
    wait_cyc(x);
    wdi = 1'b0;
    wait_cyc(x + len);
    wdi = 1'b1;
  endtask

  // a service acted on at edge act
  task automatic kick(input int act);
    pulse_low(act - LAT, N + 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired cyc=%0d expected end", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    check_at(1, 1'b0, "R2 held in reset");
    wait_cyc(2);
    rst_n = 1'b1;
    check_at(2 + T - 1, 1'b0, "R2 low after reset");
    check_at(2 + T, 1'b1, "R2 release after reset");
    er = 2 + T;

    // first legal service, rise lands inside new early window
    k1 = er + Q + 1;
    kick(k1);
    check_at(k1, 1'b1, "R5 service at Q+1 accepted");
    check_at(k1 + Q, 1'b1, "R1 rising edge ignored");

    // service on the last cycle of the short window
    k2 = k1 + LS;
    kick(k2);
    check_at(k2, 1'b1, "R6 last-cycle service accepted");
    check_at(k2 + LS - 1, 1'b1, "R6 before short timeout");
    check_at(k2 + LS, 1'b0, "R6 short timeout");
    t1 = k2 + LS;
    check_at(t1 + T - 1, 1'b0, "R3 pulse length");
    check_at(t1 + T, 1'b1, "R3 pulse release");
    er = t1 + T;

    // early service
    e = er + Q;
    kick(e);
    check_at(e - 1, 1'b1, "R4 before early service");
    check_at(e, 1'b0, "R4 early service fails");
    check_at(e + T - 1, 1'b0, "R3 pulse length after early");
    check_at(e + T, 1'b1, "R3 release after early");
    er = e + T;

    // short glitch inside early window: would fail if counted
    pulse_low(er + 1, N - 1);
    check_at(er + Q + 2, 1'b1, "R9 short glitch ignored");

    // no service: long window
    check_at(er + LL - 1, 1'b1, "R7 before long timeout");
    check_at(er + LL, 1'b0, "R7 long timeout");
    check_at(er + LL + T, 1'b1, "R3 release after long timeout");
    er = er + LL + T;

    // exactly N cycles low is a service
    a = er + 20 + LAT;
    pulse_low(er + 20, N);
    check_at(a + LS - 1, 1'b1, "R9 exact width accepted");
    check_at(a + LS, 1'b0, "R9 short window after exact pulse");
    er = a + LS + T;
    check_at(er, 1'b1, "R3 release before uvlo");

    // undervoltage
    wait_cyc(er + 5);
    uvlo = 1'b1;
    #1;
    total++;
    if (wdo_n !== 1'b0) begin
      bad++;
      $display("FAIL R8 async uvlo wdo_n=%b expected 0", wdo_n);
    end
    wait_cyc(er + 8);
    uvlo = 1'b0;
    y = er + 8;
    check_at(y + T - 1, 1'b0, "R8 low after uvlo");
    check_at(y + T, 1'b1, "R8 release after uvlo");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule